// File: doc/BRIEF.md
# Two-Phase Serial Audio Framer

This block sits between a parallel PCM word stream and a three-wire serial audio link made of a bit clock, a frame sync and a data line. It sends words from the transmit side and collects words on the receive side in the same frame timing. The bit clock reaches the block as two one-cycle strobes, one for each edge, already brought into the system clock domain. The frame sync and the receive data arrive as resynchronised levels. The block never generates clocks.

A frame has either one phase or two. Each phase has its own word count and its own word-length code, so one frame can mix word sizes, for example a 12-bit word followed by a 24-bit word. The first data bit can come 0 or 1 bit clock after the frame sync. The bit-clock edge roles and the active level of the frame sync can each be inverted. Common framings map onto these settings:
- I2S-style: 1-bit delay with an active-low sync.
- Left-aligned, and DSP framing with a 1-bit delay: active-high sync, delay 1 for DSP.
- DSP framing with no delay: active-high sync, delay 0.

For stereo, each of the two phases carries one word.

Words cross the parallel side through a valid/ready pair in each direction. Three sticky flags record faults: a missing transmit word, a receive word that was lost, and a frame sync that arrived while a frame was still running. The configuration inputs must stay constant while a frame is in progress.

Top module: `sap_framer`

## Requirements
- R1: After reset, txOut, txReady and rxValid are 0, and all three sticky flags are 0.
- R2: The 3-bit word-length code sets the bits per word as follows: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32. The reserved codes 6 and 7 also give 32 bits.
- R3: Each phase carries its length field plus one words. With dualPhase=0, only phase 1 is used. With dualPhase=1, phase 2 follows phase 1 using its own length field and its own code.
- R4: A frame starts on a drive edge where the frame sync is active and was inactive on the previous drive edge. With dataDelay=0, the first data bit is driven on that same drive edge. With dataDelay=1, it is driven on the next drive edge.
- R5: Each word is sent as the low W bits of txData, most significant bit first, one bit per drive edge. txReady is a one-cycle pulse in the cycle where the first bit of a word is driven, and the word is taken when txValid is also high in that cycle. On every drive edge that carries no data bit, txOut is driven to 0.
- R6: rxIn is sampled on the sample edge that follows each driven bit. After the last bit of a word, rxData holds that word right-aligned and zero-extended, and rxValid stays at 1 until a cycle in which rxReady is 1.
- R7: With clkInv=0, the falling-edge strobe is the drive edge and the rising-edge strobe is the sample edge. With clkInv=1, the two roles swap. With fsInv=0, the frame sync is active low. With fsInv=1, it is active high.
- R8: If txValid is 0 when a word starts, that word is sent as zeros and txUnderrun is set and stays set until reset.
- R9: If a receive word completes while rxValid is still 1 and rxReady is 0, the new word replaces rxData and rxOverrun is set and stays set until reset.
- R10: A frame lasts from its start edge until its last bit has been sampled. A frame-sync start that arrives inside that window is ignored: the current frame continues unchanged. fsError is set and stays set until reset.
- R11: A frame of 16 words in total, split as 8 words in each phase, transfers all 16 words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bclkRise | input | 1 | One-cycle strobe on a rising bit-clock edge |
| bclkFall | input | 1 | One-cycle strobe on a falling bit-clock edge |
| fsIn | input | 1 | Resynchronised frame-sync level |
| rxIn | input | 1 | Resynchronised serial receive data |
| clkInv | input | 1 | Swaps the drive and sample edges |
| fsInv | input | 1 | 0: frame sync active low, 1: active high |
| dataDelay | input | 1 | Bit clocks from frame sync to the first data bit (0 or 1) |
| dualPhase | input | 1 | Enables phase 2 |
| p1Len | input | 7 | Phase 1 word count minus one |
| p1Code | input | 3 | Phase 1 word-length code |
| p2Len | input | 7 | Phase 2 word count minus one |
| p2Code | input | 3 | Phase 2 word-length code |
| txData | input | 32 | Transmit word, right-aligned |
| txValid | input | 1 | Transmit word valid |
| txReady | output | 1 | Transmit word taken this cycle |
| rxData | output | 32 | Received word, right-aligned |
| rxValid | output | 1 | Received word valid |
| rxReady | input | 1 | Consumer takes the received word |
| txOut | output | 1 | Serial transmit data |
| txUnderrun | output | 1 | Sticky: a word started with no valid transmit word |
| rxOverrun | output | 1 | Sticky: a received word was lost |
| fsError | output | 1 | Sticky: a frame sync arrived during a frame |

## Verification
The bench loops txOut back into rxIn and runs every check on the port values.

Suppose the bit counter, word index or phase register holds a wrong value. The serial stream recorded at the sample edges then departs from the expected bit sequence at the first bit that is wrong. This shows up within one bit period of the fault, and the word returned on the receive side shows it again at the end of that word. A frame that runs too long or too short becomes visible as a non-zero idle bit after the frame, or as a missing or extra txReady pulse.

A stuck or corrupted sticky flag register is visible directly on its output pin at the end of the scenario that should set the flag, or at the end of one that should leave it clear.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int WORD_W = 32;
  localparam int BITS_W = 6;

  // Per-cycle commands from the frame sequencer to the shift datapath
  typedef struct packed {
    logic              driveEdge;
    logic              txLoad;
    logic              txShift;
    logic [BITS_W-1:0] loadBits;
    logic              rxSample;
    logic              rxLast;
  } sapStrobes_t;

  function automatic logic [BITS_W-1:0] codeToBits(input logic [2:0] code);
    case (code)
      3'd0:    return BITS_W'(8);
      3'd1:    return BITS_W'(12);
      3'd2:    return BITS_W'(16);
      3'd3:    return BITS_W'(20);
      3'd4:    return BITS_W'(24);
      default: return BITS_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclkRise,
  input  logic             bclkFall,
  input  logic             fsIn,
  input  logic             clkInv,
  input  logic             fsInv,
  input  logic             dataDelay,
  input  logic             dualPhase,
  input  logic [LEN_W-1:0] p1Len,
  input  logic [2:0]       p1Code,
  input  logic [LEN_W-1:0] p2Len,
  input  logic [2:0]       p2Code,
  output sapStrobes_t      stb,
  output logic             fsError
);
  logic driveStb, sampleStb, fsAct, fsPrev, fsEdge, busy;
  logic active, delayPend, phase2, sampPend, sampLast;
  logic [LEN_W-1:0]  wordIdx, curLen;
  logic [BITS_W-1:0] bitRem, p1Bits, p2Bits, curBits;
  logic startNow, firstBit, contBit, wordEnd, moreInPhase, toPhase2, lastBit;

  assign driveStb    = clkInv ? bclkRise : bclkFall;
  assign sampleStb   = clkInv ? bclkFall : bclkRise;
  assign fsAct       = (fsIn == fsInv);
  assign fsEdge      = driveStb && fsAct && !fsPrev;
  assign busy        = active || sampPend;
  assign startNow    = fsEdge && !busy;
  assign firstBit    = (startNow && !dataDelay) || (driveStb && active && delayPend);
  assign contBit     = driveStb && active && !delayPend;
  assign p1Bits      = codeToBits(p1Code);
  assign p2Bits      = codeToBits(p2Code);
  assign curLen      = phase2 ? p2Len : p1Len;
  assign curBits     = phase2 ? p2Bits : p1Bits;
  assign wordEnd     = (bitRem == '0);
  assign moreInPhase = (wordIdx != curLen);
  assign toPhase2    = !phase2 && dualPhase;
  assign lastBit     = contBit && !wordEnd && (bitRem == BITS_W'(1)) && !moreInPhase && !toPhase2;

  always_comb begin
    stb           = '0;
    stb.driveEdge = driveStb;
    stb.txLoad    = firstBit || (contBit && wordEnd);
    stb.txShift   = contBit && !wordEnd;
    stb.loadBits  = firstBit ? p1Bits : (moreInPhase ? curBits : p2Bits);
    stb.rxSample  = sampleStb && sampPend;
    stb.rxLast    = sampLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev <= 1'b0; fsError <= 1'b0; active <= 1'b0; delayPend <= 1'b0;
      phase2 <= 1'b0; wordIdx <= '0; bitRem <= '0; sampPend <= 1'b0; sampLast <= 1'b0;
    end else begin
      if (driveStb) fsPrev <= fsAct;
      if (fsEdge && busy) fsError <= 1'b1;
      if (sampleStb) sampPend <= 1'b0;
      if (startNow) begin
        active    <= 1'b1;
        delayPend <= dataDelay;
      end
      if (firstBit) begin
        delayPend <= 1'b0;
        phase2    <= 1'b0;
        wordIdx   <= '0;
        bitRem    <= p1Bits - BITS_W'(1);
        sampPend  <= 1'b1;
        sampLast  <= 1'b0;
      end else if (contBit) begin
        sampPend <= 1'b1;
        if (!wordEnd) begin
          bitRem   <= bitRem - BITS_W'(1);
          sampLast <= (bitRem == BITS_W'(1));
          if (lastBit) active <= 1'b0;
        end else if (moreInPhase) begin
          wordIdx  <= wordIdx + LEN_W'(1);
          bitRem   <= curBits - BITS_W'(1);
          sampLast <= 1'b0;
        end else begin
          phase2   <= 1'b1;
          wordIdx  <= '0;
          bitRem   <= p2Bits - BITS_W'(1);
          sampLast <= 1'b0;
        end
      end
    end
  end

  // R10: the frame-sync error flag never clears once raised
  assert_fs_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    fsError |=> fsError);
  // R10: a second sync inside a frame never restarts the word sequence
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fsEdge && contBit) |-> !firstBit);
endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sapStrobes_t       stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              rxIn,
  input  logic              rxReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txOut,
  output logic              txUnderrun,
  output logic              rxOverrun
);
  logic [DATA_W-1:0] txSh, rxSh, txAligned, rxNext;

  assign txReady   = stb.txLoad;
  assign txAligned = txValid ? (txData << (DATA_W - int'(stb.loadBits))) : '0;
  assign rxNext    = {rxSh[DATA_W-2:0], rxIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0; txOut <= 1'b0; txUnderrun <= 1'b0;
    end else if (stb.txLoad) begin
      txOut <= txAligned[DATA_W-1];
      txSh  <= txAligned << 1;
      if (!txValid) txUnderrun <= 1'b1;
    end else if (stb.txShift) begin
      txOut <= txSh[DATA_W-1];
      txSh  <= txSh << 1;
    end else if (stb.driveEdge) begin
      txOut <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0; rxData <= '0; rxValid <= 1'b0; rxOverrun <= 1'b0;
    end else if (stb.rxSample && stb.rxLast) begin
      rxData  <= rxNext;
      rxSh    <= '0;
      rxValid <= 1'b1;
      if (rxValid && !rxReady) rxOverrun <= 1'b1;
    end else begin
      if (stb.rxSample) rxSh <= rxNext;
      if (rxValid && rxReady) rxValid <= 1'b0;
    end
  end

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |=> txUnderrun);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);
  assert_rx_valid_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(stb.rxSample && stb.rxLast));
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !(stb.rxSample && stb.rxLast)) |=> (rxValid && $stable(rxData)));
endmodule

// File: rtl/sap_framer.sv
module sap_framer
  import sap_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkRise,
  input  logic              bclkFall,
  input  logic              fsIn,
  input  logic              rxIn,
  input  logic              clkInv,
  input  logic              fsInv,
  input  logic              dataDelay,
  input  logic              dualPhase,
  input  logic [LEN_W-1:0]  p1Len,
  input  logic [2:0]        p1Code,
  input  logic [LEN_W-1:0]  p2Len,
  input  logic [2:0]        p2Code,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              txOut,
  output logic              txUnderrun,
  output logic              rxOverrun,
  output logic              fsError
);
  sapStrobes_t ctlStb;

  sap_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bclkRise(bclkRise), .bclkFall(bclkFall), .fsIn(fsIn),
    .clkInv(clkInv), .fsInv(fsInv), .dataDelay(dataDelay), .dualPhase(dualPhase),
    .p1Len(p1Len), .p1Code(p1Code), .p2Len(p2Len), .p2Code(p2Code),
    .stb(ctlStb), .fsError(fsError)
  );

  sap_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxIn(rxIn), .rxReady(rxReady), .rxData(rxData),
    .rxValid(rxValid), .txOut(txOut), .txUnderrun(txUnderrun), .rxOverrun(rxOverrun)
  );

  // R7: the serial output moves only on the edge selected as the drive edge
  assert_tx_on_drive_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txOut) |-> $past(clkInv ? bclkRise : bclkFall));
  // R5: a new transmit word is never requested on two cycles in a row
  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);
endmodule

// File: tb/sim_sap_framer.sv
module sim_sap_framer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, bclkRise, bclkFall, fsIn, rxIn, clkInv, fsInv, dataDelay, dualPhase;
  logic [6:0] p1Len, p2Len;
  logic [2:0] p1Code, p2Code;
  logic [31:0] txData, rxData;
  logic txValid, txReady, rxValid, rxReady, txOut, txUnderrun, rxOverrun, fsError;

  assign rxIn = txOut;

  sap_framer u0 (
    .clk(clk), .rstN(rstN), .bclkRise(bclkRise), .bclkFall(bclkFall), .fsIn(fsIn),
    .rxIn(rxIn), .clkInv(clkInv), .fsInv(fsInv), .dataDelay(dataDelay),
    .dualPhase(dualPhase), .p1Len(p1Len), .p1Code(p1Code), .p2Len(p2Len),
    .p2Code(p2Code), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .txOut(txOut),
    .txUnderrun(txUnderrun), .rxOverrun(rxOverrun), .fsError(fsError)
  );

  int checks = 0, errors = 0, ph = 0;
  int txIdx = 0, txQn = 0, rxN = 0, bitN = 0;
  bit txEn = 1, rec = 0, driveNext = 0, sampNext = 0;
  logic fsReq = 1'b1, fsInvReq = 1'b0, clkInvReq = 1'b0;
  logic [31:0] txQ [0:16];
  logic [31:0] rxGot [0:16];
  logic [31:0] expW [0:16];
  logic bits [0:511];
  logic expB [0:511];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bitsOf(input int code);
    case (code)
      0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
    fsIn = fsReq; fsInv = fsInvReq; clkInv = clkInvReq;
    ph = (ph + 1) % 8;
    bclkRise = (ph == 0);
    bclkFall = (ph == 4);
    driveNext = clkInv ? bclkRise : bclkFall;
    sampNext  = clkInv ? bclkFall : bclkRise;
    if (rec && sampNext && bitN < 512) begin bits[bitN] = txOut; bitN++; end
    txValid = txEn && (txIdx < txQn);
    txData  = txQ[txIdx > 16 ? 16 : txIdx];
    #3;
    if (txValid && txReady) txIdx++;
    if (rxValid && rxReady && rxN < 17) begin rxGot[rxN] = rxData; rxN++; end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) tick();
    rstN = 1'b1;
    tick();
  endtask

  // Runs one frame with loopback and checks the serial stream and received words
  task automatic runFrame(input bit d, input bit dual, input int l1, input int c1,
                          input int l2, input int c2, input bit extra, input string req);
    int n, nw, w, firstBad;
    logic [31:0] v, mask;
    logic act;
    act = fsInvReq;
    dataDelay = d; dualPhase = dual;
    p1Len = l1[6:0]; p1Code = c1[2:0]; p2Len = l2[6:0]; p2Code = c2[2:0];
    n = 0;
    for (int i = 0; i < int'(d); i++) begin expB[n] = 1'b0; n++; end
    nw = (l1 + 1) + (dual ? l2 + 1 : 0);
    for (int j = 0; j < nw; j++) begin
      w = bitsOf(j <= l1 ? c1 : c2);
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      v = (txEn ? txQ[j] : 32'h0) & mask;
      expW[j] = v;
      for (int b = w - 1; b >= 0; b--) begin expB[n] = v[b]; n++; end
    end
    txIdx = 0; txQn = nw; rxN = 0; rec = 0;
    do tick(); while (!driveNext);
    fsReq = act;
    do tick(); while (!driveNext);
    fsReq = ~act; bitN = 0; rec = 1;
    for (int t = 0; t < (n + 3) * 8; t++) begin
      if (extra && t == 40) fsReq = act;
      if (extra && t == 48) fsReq = ~act;
      tick();
    end
    rec = 0;
    firstBad = -1;
    for (int i = 0; i < n; i++) if (firstBad < 0 && bits[i] !== expB[i]) firstBad = i;
    chk(firstBad < 0, req, "serial bit stream (first bad index in actual)",
        32'(firstBad), 32'hFFFF_FFFF);
    chk(bits[n] === 1'b0 && bits[n+1] === 1'b0, "R5", "idle txOut after frame",
        {30'h0, bits[n], bits[n+1]}, 32'h0);
    chk(txIdx == (txEn ? nw : 0), "R5", "transmit words taken", 32'(txIdx), 32'(txEn ? nw : 0));
    if (rxReady) begin
      chk(rxN == nw, "R6", "received word count", 32'(rxN), 32'(nw));
      for (int j = 0; j < nw && j < rxN; j++)
        chk(rxGot[j] === expW[j], req, "received word", rxGot[j], expW[j]);
    end
  endtask

  task automatic tReset();
    chk(txOut === 1'b0 && txReady === 1'b0, "R1", "tx outputs after reset", {30'h0, txOut, txReady}, 32'h0);
    chk(rxValid === 1'b0, "R1", "rxValid after reset", 32'(rxValid), 32'h0);
    chk({txUnderrun, rxOverrun, fsError} === 3'b000, "R1", "flags after reset",
        {29'h0, txUnderrun, rxOverrun, fsError}, 32'h0);
  endtask

  task automatic tFlagsClear(input string req);
    chk({txUnderrun, rxOverrun, fsError} === 3'b000, req, "no spurious flags",
        {29'h0, txUnderrun, rxOverrun, fsError}, 32'h0);
  endtask

  task automatic tSinglePhase();
    txQ[0] = 32'hDEAD_A5C3; txQ[1] = 32'h0000_1E0F;
    runFrame(1'b1, 1'b0, 1, 2, 0, 0, 1'b0, "R3 R4 R5");
    tFlagsClear("R8 R9 R10");
  endtask

  task automatic tDualMixed();
    txQ[0] = 32'hFFFF_F9A5; txQ[1] = 32'h12C3_5A7E;
    runFrame(1'b0, 1'b1, 0, 1, 0, 4, 1'b0, "R2 R3 R4");
  endtask

  task automatic tSixteenWords();
    for (int j = 0; j < 16; j++) txQ[j] = 32'h9E37_79B9 * (j + 3);
    runFrame(1'b1, 1'b1, 7, 0, 7, 3, 1'b0, "R11 R2");
    tFlagsClear("R11");
  endtask

  task automatic tPolarity();
    fsInvReq = 1'b1; fsReq = 1'b0; clkInvReq = 1'b1;
    txQ[0] = 32'h8001_7FFE; txQn = 1; txIdx = 0; rxN = 0;
    repeat (100) tick();
    chk(txIdx == 0 && rxN == 0, "R7", "low sync ignored when active high",
        32'(txIdx + rxN), 32'h0);
    runFrame(1'b0, 1'b0, 0, 5, 0, 0, 1'b0, "R7 R2");
    tFlagsClear("R7");
    fsInvReq = 1'b0; fsReq = 1'b1; clkInvReq = 1'b0;
    repeat (16) tick();
  endtask

  task automatic tReservedCode();
    txQ[0] = 32'h5AF0_0FA5;
    runFrame(1'b1, 1'b0, 0, 7, 0, 0, 1'b0, "R2 reserved code");
  endtask

  task automatic tUnderrun();
    doReset();
    txEn = 0;
    runFrame(1'b1, 1'b0, 1, 2, 0, 0, 1'b0, "R8");
    chk(txUnderrun === 1'b1, "R8", "underrun flag", 32'(txUnderrun), 32'h1);
    repeat (20) tick();
    chk(txUnderrun === 1'b1, "R8", "underrun stays set", 32'(txUnderrun), 32'h1);
    txEn = 1;
  endtask

  task automatic tOverrun();
    doReset();
    txQ[0] = 32'h0000_1111; txQ[1] = 32'h0000_BEEF;
    rxReady = 1'b0;
    runFrame(1'b1, 1'b0, 1, 2, 0, 0, 1'b0, "R9");
    chk(rxOverrun === 1'b1, "R9", "overrun flag", 32'(rxOverrun), 32'h1);
    chk(rxValid === 1'b1 && rxData === 32'h0000_BEEF, "R9", "newest word kept", rxData, 32'h0000_BEEF);
    rxReady = 1'b1;
    tick();
    chk(rxValid === 1'b0, "R6", "rxValid cleared after take", 32'(rxValid), 32'h0);
    chk(txUnderrun === 1'b0 && fsError === 1'b0, "R9", "other flags clear",
        {30'h0, txUnderrun, fsError}, 32'h0);
  endtask

  task automatic tSyncError();
    doReset();
    txQ[0] = 32'h0000_C0DE; txQ[1] = 32'h0000_3A5C;
    runFrame(1'b1, 1'b0, 1, 2, 0, 0, 1'b1, "R10");
    chk(fsError === 1'b1, "R10", "frame-sync error flag", 32'(fsError), 32'h1);
    chk(txUnderrun === 1'b0 && rxOverrun === 1'b0, "R10", "no other flags",
        {30'h0, txUnderrun, rxOverrun}, 32'h0);
  endtask

  initial begin
    rstN = 1'b0; bclkRise = 1'b0; bclkFall = 1'b0; fsIn = 1'b1; clkInv = 1'b0; fsInv = 1'b0;
    dataDelay = 1'b0; dualPhase = 1'b0; p1Len = '0; p2Len = '0; p1Code = '0; p2Code = '0;
    txData = '0; txValid = 1'b0; rxReady = 1'b1;
    doReset();
    tReset();
    tSinglePhase();
    tDualMixed();
    tSixteenWords();
    tPolarity();
    tReservedCode();
    tUnderrun();
    tOverrun();
    tSyncError();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule